// File: doc/BRIEF.md
# Fast Call and Return Unit

This unit executes lightweight subroutine calls that preserve only the return address, plus the matching returns. A call pushes the current return-address register onto a word stack in memory, loads the return-address register with the next PC and sends the PC to a new target. A return does three things: it jumps to the current return address with bit 0 cleared, reloads the return-address register from the top of the stack and releases that stack word. Calls come in three forms: PC-relative, absolute and register-indirect.

The unit owns the stack-pointer and return-address registers. A decoded instruction is accepted only while the unit is idle. The unit then makes one memory access through a request/acknowledge port, commits its register updates in the cycle after the acknowledge, and issues a one-cycle redirect pulse that carries the target. The controller has four states. IDLE waits for a recognised instruction. PUSH writes the old return address. POP reads the saved return address. REDIR drives the redirect pulse. The transitions are:
- IDLE→PUSH on an accepted call.
- IDLE→POP on an accepted return.
- PUSH→REDIR and POP→REDIR on the memory acknowledge.
- REDIR→IDLE unconditionally.
- PUSH and POP stay in place while the acknowledge is low.

Top module: `qcu_top`

## Requirements
- R1: After reset, `busy`, `redirect` and `mem_req` are 0, `stack_ptr` equals SP_RST (default 0x0000_1000) and `ret_addr` equals RA_RST (default 0).
- R2: An accepted call requests a 32-bit memory write (`mem_we`=1). The write address is `stack_ptr`-4 and the write data is the old `ret_addr`.
- R3: In the cycle after a call's write is acknowledged, `ret_addr` equals the `nxt_pc` presented at issue and `stack_ptr` has dropped by 4.
- R4: A 32-bit instruction (`op_short`=0) with `op_major`=0x61 is a relative call. Its target is `cur_pc` plus twice the sign-extended 24-bit `br_offset`.
- R5: A 32-bit instruction with `op_major`=0xE1 is an absolute call. Its target has `br_offset[23:20]` in bits 31:28 and `br_offset[19:0]` in bits 20:1. All other target bits are 0.
- R6: A 32-bit instruction with `op_major`=0x2D and `op_minor`=0x01 is an indirect call. Its target is `areg_val` with bit 0 cleared.
- R7: Two encodings select a return: a 32-bit instruction with `op_major`=0x0D and `op_minor`=0x03, or a 16-bit instruction (`op_short`=1) with `op_major`=0x00 and `op_minor`=0x07. A return reads memory at `stack_ptr` (`mem_we`=0). After the acknowledge, `ret_addr` holds the word read and `stack_ptr` has grown by 4. The target is the pre-return `ret_addr` with bit 0 cleared.
- R8: While `mem_req` is high and `mem_ack` is low, the request, address, `stack_ptr` and `ret_addr` all stay unchanged.
- R9: `redirect` is a single-cycle pulse in the cycle after the acknowledge, and it carries `redirect_pc`. `busy` is high from the cycle after issue through the redirect cycle and low afterwards.
- R10: The unit ignores any unrecognised encoding and any issue made while it is busy. Such an issue produces no request, no redirect and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| op_short | input | 1 | 1 for a 16-bit encoding |
| op_major | input | 8 | Primary opcode |
| op_minor | input | 8 | Secondary opcode |
| br_offset | input | 24 | Branch offset field |
| areg_val | input | 32 | Address register value for the indirect call |
| cur_pc | input | 32 | PC of the instruction |
| nxt_pc | input | 32 | PC of the following instruction |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Unit occupied |
| redirect | output | 1 | Branch-taken pulse |
| redirect_pc | output | 32 | New PC, valid with `redirect` |
| stack_ptr | output | 32 | Stack-pointer register |
| ret_addr | output | 32 | Return-address register |

## Verification
The bench checks the absolute call with a mixed offset, which a wrong field placement would scatter into the wrong address bits. It also checks a relative call with a negative offset, where missing sign extension would jump far forward. It stalls the acknowledge for several cycles to catch early register commits, which would leave a wrong stack pointer visible while memory is busy. It presents near-miss encodings and issues an instruction while the unit is busy, so a loose decoder or a missing idle guard would show up as an extra request or redirect. Returns use an odd saved address and both return encodings, so the bench catches a target that keeps bit 0 or that comes from the reloaded value.

// File: rtl/qcu_pkg.sv
package qcu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP,
        ST_REDIR
    } qcu_state_e;

    typedef enum logic [2:0] {
        OPK_NONE,
        OPK_CALL_REL,
        OPK_CALL_ABS,
        OPK_CALL_IND,
        OPK_RET
    } qcu_opkind_e;

endpackage

// File: rtl/qcu_decode.sv
module qcu_decode
    import qcu_pkg::*;
#(
    parameter int XLEN          = 32,
    parameter int OFFW          = 24,
    parameter int OPW           = 8,
    parameter logic [OPW-1:0] OPC_REL       = 8'h61,
    parameter logic [OPW-1:0] OPC_ABS       = 8'hE1,
    parameter logic [OPW-1:0] OPC_IND_GRP   = 8'h2D,
    parameter logic [OPW-1:0] SUB_IND       = 8'h01,
    parameter logic [OPW-1:0] OPC_SYS_GRP   = 8'h0D,
    parameter logic [OPW-1:0] SUB_RET_LONG  = 8'h03,
    parameter logic [OPW-1:0] OPC_SHORT_GRP = 8'h00,
    parameter logic [OPW-1:0] SUB_RET_SHORT = 8'h07
) (
    input  logic            op_short,
    input  logic [OPW-1:0]  op_major,
    input  logic [OPW-1:0]  op_minor,
    input  logic [OFFW-1:0] br_offset,
    input  logic [XLEN-1:0] areg_val,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] ret_addr,
    output qcu_opkind_e     kind,
    output logic [XLEN-1:0] target
);
    localparam int PADW = XLEN - OFFW - 1;
    localparam int HIW  = 4;
    localparam logic [XLEN-1:0] BIT0_CLR = ~XLEN'(1);

    logic [XLEN-1:0] rel_disp;
    logic [XLEN-1:0] abs_tgt;

    always_comb begin
        rel_disp = {{PADW{br_offset[OFFW-1]}}, br_offset, 1'b0};
        abs_tgt  = {br_offset[OFFW-1 -: HIW], {PADW{1'b0}},
                    br_offset[OFFW-HIW-1:0], 1'b0};
    end

    always_comb begin
        kind = OPK_NONE;
        if (op_short) begin
            if (op_major == OPC_SHORT_GRP && op_minor == SUB_RET_SHORT)
                kind = OPK_RET;
        end else begin
            if (op_major == OPC_REL)
                kind = OPK_CALL_REL;
            else if (op_major == OPC_ABS)
                kind = OPK_CALL_ABS;
            else if (op_major == OPC_IND_GRP && op_minor == SUB_IND)
                kind = OPK_CALL_IND;
            else if (op_major == OPC_SYS_GRP && op_minor == SUB_RET_LONG)
                kind = OPK_RET;
        end
    end

    always_comb begin
        unique case (kind)
            OPK_CALL_REL: target = cur_pc + rel_disp;
            OPK_CALL_ABS: target = abs_tgt;
            OPK_CALL_IND: target = areg_val & BIT0_CLR;
            OPK_RET:      target = ret_addr & BIT0_CLR;
            default:      target = '0;
        endcase
    end

endmodule

// File: rtl/qcu_fsm.sv
module qcu_fsm
    import qcu_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  qcu_opkind_e     kind,
    input  logic [XLEN-1:0] target,
    input  logic [XLEN-1:0] nxt_pc,
    input  logic [XLEN-1:0] sp_cur,
    input  logic [XLEN-1:0] ra_cur,
    input  logic            mem_ack,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            busy,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] link_pc,
    output logic            push_done,
    output logic            pop_done
);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    qcu_state_e      state, state_nx;
    logic            accept;
    logic [XLEN-1:0] addr_q, wdata_q, tgt_q, link_q;

    assign accept = (state == ST_IDLE) && issue_valid && (kind != OPK_NONE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = (kind == OPK_RET) ? ST_POP : ST_PUSH;
            ST_PUSH:  if (mem_ack) state_nx = ST_REDIR;
            ST_POP:   if (mem_ack) state_nx = ST_REDIR;
            ST_REDIR: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            tgt_q   <= '0;
            link_q  <= '0;
        end else if (accept) begin
            addr_q  <= (kind == OPK_RET) ? sp_cur : sp_cur - STEP;
            wdata_q <= ra_cur;
            tgt_q   <= target;
            link_q  <= nxt_pc;
        end
    end

    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        redirect    = 1'b0;
        push_done   = 1'b0;
        pop_done    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                push_done = mem_ack;
            end
            ST_POP: begin
                mem_req  = 1'b1;
                pop_done = mem_ack;
            end
            ST_REDIR: redirect = 1'b1;
            default: ;
        endcase
        busy        = (state != ST_IDLE);
        mem_addr    = addr_q;
        mem_wdata   = wdata_q;
        redirect_pc = tgt_q;
        link_pc     = link_q;
    end

endmodule

// File: rtl/qcu_regs.sv
module qcu_regs #(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4,
    parameter logic [XLEN-1:0] SP_RST = 32'h0000_1000,
    parameter logic [XLEN-1:0] RA_RST = 32'h0000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_done,
    input  logic            pop_done,
    input  logic [XLEN-1:0] push_sp,
    input  logic [XLEN-1:0] link_pc,
    input  logic [XLEN-1:0] pop_word,
    output logic [XLEN-1:0] sp_q,
    output logic [XLEN-1:0] ra_q
);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_RST;
            ra_q <= RA_RST;
        end else if (push_done) begin
            sp_q <= push_sp;
            ra_q <= link_pc;
        end else if (pop_done) begin
            sp_q <= sp_q + STEP;
            ra_q <= pop_word;
        end
    end

endmodule

// File: rtl/qcu_top.sv
module qcu_top
    import qcu_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int OFFW       = 24,
    parameter int OPW        = 8,
    parameter int WORD_BYTES = 4,
    parameter logic [XLEN-1:0] SP_RST = 32'h0000_1000,
    parameter logic [XLEN-1:0] RA_RST = 32'h0000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic            op_short,
    input  logic [OPW-1:0]  op_major,
    input  logic [OPW-1:0]  op_minor,
    input  logic [OFFW-1:0] br_offset,
    input  logic [XLEN-1:0] areg_val,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] nxt_pc,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic            mem_ack,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            busy,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] stack_ptr,
    output logic [XLEN-1:0] ret_addr
);
    qcu_opkind_e     kind;
    logic [XLEN-1:0] target, link_pc;
    logic            push_done, pop_done;

    qcu_decode #(.XLEN(XLEN), .OFFW(OFFW), .OPW(OPW)) u_dec (
        .op_short (op_short),
        .op_major (op_major),
        .op_minor (op_minor),
        .br_offset(br_offset),
        .areg_val (areg_val),
        .cur_pc   (cur_pc),
        .ret_addr (ret_addr),
        .kind     (kind),
        .target   (target)
    );

    qcu_fsm #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_valid(issue_valid),
        .kind       (kind),
        .target     (target),
        .nxt_pc     (nxt_pc),
        .sp_cur     (stack_ptr),
        .ra_cur     (ret_addr),
        .mem_ack    (mem_ack),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .redirect   (redirect),
        .redirect_pc(redirect_pc),
        .link_pc    (link_pc),
        .push_done  (push_done),
        .pop_done   (pop_done)
    );

    qcu_regs #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES),
               .SP_RST(SP_RST), .RA_RST(RA_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_done(push_done),
        .pop_done (pop_done),
        .push_sp  (mem_addr),
        .link_pc  (link_pc),
        .pop_word (mem_rdata),
        .sp_q     (stack_ptr),
        .ra_q     (ret_addr)
    );

endmodule

// File: rtl/qcu_checker.sv
module qcu_checker #(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            redirect,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_rdata,
    input logic [XLEN-1:0] stack_ptr,
    input logic [XLEN-1:0] ret_addr
);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    a_r2_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_addr == stack_ptr - STEP);

    a_r3_push_commit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> stack_ptr == $past(mem_addr));

    a_r7_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> mem_addr == stack_ptr);

    a_r7_pop_commit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack |=>
            ret_addr == $past(mem_rdata) && stack_ptr == $past(stack_ptr) + STEP);

    a_r8_stall_regs: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> $stable(stack_ptr) && $stable(ret_addr));

    a_r8_stall_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    a_r9_redirect_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);

    a_r9_busy_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> busy);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !redirect);

endmodule

bind qcu_top qcu_checker #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .redirect (redirect),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_rdata(mem_rdata),
    .stack_ptr(stack_ptr),
    .ret_addr (ret_addr)
);

// File: tb/qcu_top_tb.sv
module qcu_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        issue_valid = 0;
    logic        op_short = 0;
    logic [7:0]  op_major = 0, op_minor = 0;
    logic [23:0] br_offset = 0;
    logic [31:0] areg_val = 0, cur_pc = 0, nxt_pc = 0;
    logic        mem_req, mem_we, mem_ack = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
    logic        busy, redirect;
    logic [31:0] redirect_pc, stack_ptr, ret_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    qcu_top u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .op_short(op_short),
        .op_major(op_major), .op_minor(op_minor), .br_offset(br_offset),
        .areg_val(areg_val), .cur_pc(cur_pc), .nxt_pc(nxt_pc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .redirect(redirect), .redirect_pc(redirect_pc),
        .stack_ptr(stack_ptr), .ret_addr(ret_addr)
    );

    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic [31:0] wdata;
        logic [31:0] tgt;
        logic [31:0] sp_pre, ra_pre, sp_post, ra_post;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    logic [31:0] mem_m [logic [31:0]];
    logic [31:0] m_sp = 32'h0000_1000, m_ra = 32'h0;
    int          stall_cycles = 0, stall_cnt = 0;
    int          n_tests = 0, n_fail = 0;
    int          cycles = 0;
    bit          done = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_model(input logic [31:0] a);
        if (mem_m.exists(a)) return mem_m[a];
        return 32'h0;
    endfunction

    // memory responder: checks request fields against the scoreboard head
    always @(negedge clk) begin
        if (!rst_n || !mem_req) begin
            mem_ack   <= 1'b0;
            stall_cnt <= 0;
        end else if (expq.size() == 0) begin
            check(1'b0, "R10 unexpected memory request", mem_addr, 32'h0);
            mem_ack <= 1'b1;
        end else if (stall_cnt < stall_cycles) begin
            stall_cnt <= stall_cnt + 1;
            mem_ack   <= 1'b0;
            check(stack_ptr == expq[0].sp_pre, "R8 stack_ptr during stall", stack_ptr, expq[0].sp_pre);
            check(ret_addr == expq[0].ra_pre, "R8 ret_addr during stall", ret_addr, expq[0].ra_pre);
        end else begin
            check(mem_addr == expq[0].addr, {expq[0].tag, " mem_addr"}, mem_addr, expq[0].addr);
            check(mem_we == expq[0].we, {expq[0].tag, " mem_we"}, 32'(mem_we), 32'(expq[0].we));
            if (expq[0].we) begin
                check(mem_wdata == expq[0].wdata, "R2 mem_wdata", mem_wdata, expq[0].wdata);
                mem_m[mem_addr] = mem_wdata;
            end else begin
                mem_rdata <= rd_model(mem_addr);
            end
            mem_ack <= 1'b1;
        end
    end

    // monitor: pops the scoreboard on each redirect pulse
    always @(negedge clk) begin
        if (rst_n && redirect) begin
            if (expq.size() == 0) begin
                check(1'b0, "R10 unexpected redirect", redirect_pc, 32'h0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(redirect_pc == e.tgt, {e.tag, " redirect_pc"}, redirect_pc, e.tgt);
                check(stack_ptr == e.sp_post, {e.tag, " stack_ptr after ack"}, stack_ptr, e.sp_post);
                check(ret_addr == e.ra_post, {e.tag, " ret_addr after ack"}, ret_addr, e.ra_post);
                check(busy == 1'b1, "R9 busy during redirect", 32'(busy), 32'h1);
            end
        end
    end

    // kind: 0 ignored, 1 relative, 2 absolute, 3 indirect, 4 return
    task automatic run_op(input logic sh, input logic [7:0] maj, input logic [7:0] mn,
                          input logic [23:0] off, input logic [31:0] areg,
                          input logic [31:0] cpc, input logic [31:0] npc,
                          input int stall, input int kind, input bit inject,
                          input string tag);
        exp_t e;
        @(negedge clk);
        op_short = sh; op_major = maj; op_minor = mn; br_offset = off;
        areg_val = areg; cur_pc = cpc; nxt_pc = npc;
        stall_cycles = stall;
        issue_valid = 1'b1;
        e.sp_pre = m_sp; e.ra_pre = m_ra; e.tag = tag;
        if (kind == 4) begin
            e.addr = m_sp; e.we = 1'b0; e.wdata = 32'h0;
            e.tgt = {m_ra[31:1], 1'b0};
            e.sp_post = m_sp + 32'd4;
            e.ra_post = rd_model(m_sp);
        end else begin
            e.addr = m_sp - 32'd4; e.we = 1'b1; e.wdata = m_ra;
            e.sp_post = m_sp - 32'd4;
            e.ra_post = npc;
            case (kind)
                1: e.tgt = cpc + {{7{off[23]}}, off, 1'b0};
                2: e.tgt = {off[23:20], 7'b0, off[19:0], 1'b0};
                default: e.tgt = {areg[31:1], 1'b0};
            endcase
        end
        if (kind != 0) begin
            expq.push_back(e);
            m_sp = e.sp_post;
            m_ra = e.ra_post;
        end
        @(negedge clk);
        issue_valid = 1'b0;
        if (kind != 0)
            check(busy == 1'b1, "R9 busy after issue", 32'(busy), 32'h1);
        if (inject) begin
            op_short = 1'b0; op_major = 8'h61; br_offset = 24'h000100;
            nxt_pc = 32'hDEAD_0000;
            issue_valid = 1'b1;
            @(negedge clk);
            issue_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R9 busy low after redirect", 32'(busy), 32'h0);
        check(mem_req == 1'b0, "R10 no request when idle", 32'(mem_req), 32'h0);
        check(expq.size() == 0, {tag, " scoreboard drained"}, 32'(expq.size()), 32'h0);
        check(stack_ptr == m_sp, {tag, " stack_ptr settled"}, stack_ptr, m_sp);
        check(ret_addr == m_ra, {tag, " ret_addr settled"}, ret_addr, m_ra);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", 32'(busy), 32'h0);
        check(redirect == 1'b0, "R1 redirect after reset", 32'(redirect), 32'h0);
        check(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 32'h0);
        check(stack_ptr == 32'h0000_1000, "R1 stack_ptr after reset", stack_ptr, 32'h0000_1000);
        check(ret_addr == 32'h0, "R1 ret_addr after reset", ret_addr, 32'h0);

        run_op(1'b0, 8'h61, 8'h00, 24'h000010, 32'h0, 32'h8000_0100, 32'h8000_0104,
               0, 1, 1'b0, "R4/R2/R3 relative forward");
        run_op(1'b0, 8'h61, 8'h5A, 24'hFFFFF0, 32'h0, 32'h8000_0200, 32'h8000_0204,
               2, 1, 1'b0, "R4/R8 relative backward");
        run_op(1'b0, 8'hE1, 8'h00, 24'hABCDEF, 32'h0, 32'h8000_0300, 32'h8000_0304,
               1, 2, 1'b0, "R5 absolute");
        run_op(1'b0, 8'h2D, 8'h01, 24'h0, 32'h9000_1235, 32'h8000_0400, 32'h8000_0403,
               0, 3, 1'b1, "R6/R10 indirect with busy issue");
        run_op(1'b0, 8'h0D, 8'h03, 24'h0, 32'h0, 32'h9000_1234, 32'h9000_1238,
               3, 4, 1'b0, "R7/R8 long return");
        run_op(1'b1, 8'h00, 8'h07, 24'h0, 32'h0, 32'h0, 32'h0,
               0, 4, 1'b0, "R7 short return");
        run_op(1'b1, 8'h61, 8'h00, 24'h000020, 32'h0, 32'h8000_0500, 32'h8000_0502,
               0, 0, 1'b0, "R10 short form of call opcode");
        run_op(1'b0, 8'h0D, 8'h04, 24'h0, 32'h0, 32'h0, 32'h0,
               0, 0, 1'b0, "R10 system group other minor");
        run_op(1'b0, 8'h2D, 8'h02, 24'h0, 32'h1111_1111, 32'h0, 32'h0,
               0, 0, 1'b0, "R10 indirect group other minor");
        run_op(1'b0, 8'h0D, 8'h03, 24'h0, 32'h0, 32'h0, 32'h0,
               1, 4, 1'b0, "R7 long return second");
        run_op(1'b1, 8'h00, 8'h07, 24'h0, 32'h0, 32'h0, 32'h0,
               2, 4, 1'b0, "R7/R8 short return to base");
        run_op(1'b0, 8'hE1, 8'h00, 24'hF00001, 32'h0, 32'h8000_0600, 32'h8000_0604,
               0, 2, 1'b0, "R5 absolute top nibble");

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule